// File: doc/BRIEF.md
# Key-Protected Clock and Power Control Unit

This block sits beside a small microcontroller core and runs from a 4.096 MHz reference clock. It holds one power-control register that software can change only through an unlock key. From that register it makes a core clock enable at a binary submultiple of the reference, selected by a 3-bit exponent. It also makes a fixed divide-by-5 enable for the metering logic, which runs at 819.2 kHz whatever the core speed is.

The block watches the lock indication of the frequency synthesizer. If lock is lost, it requests a core reset and sets a sticky fault flag. Software reads that flag after the reset and clears it with an explicit acknowledge write. All register access goes through a byte-wide special-function-register bus. Writes take one cycle. Reads are combinational on the address.

Top module: `clkpwr_unit`

## Requirements
- R1: After power-on reset the divider exponent is 2 (core enable every 4 cycles). The power-control register reads 0x82, the status register reads 0x00, and resetReq, coreOff and meterOff are all low.
- R2: A write to the power-control register (address 0xC5) takes effect only if the write just before it was 0xA7 to the key register (address 0xC1). Without that, the write leaves the register unchanged.
- R3: The unlock is used up by the next write to any address. A key followed by a write elsewhere, or by another key byte, leaves the power-control register locked.
- R4: Writing 0xEA to the key register does not unlock the power-control register.
- R5: With exponent value n (bits [2:0]), coreClkEn is a one-cycle pulse every 2^n reference cycles, for every n from 0 to 7.
- R6: A new exponent takes effect only after the core enable period already running has completed. No period is shortened.
- R7: meterClkEn is a one-cycle pulse every 5 reference cycles, whatever the exponent is.
- R8: Bit 6 of the power-control register drives meterOff and bit 4 drives coreOff. Read back, bit 7 is always 1 and bits 5 and 3 are always 0, whatever was written.
- R9: A 1-to-0 change of pllLocked raises resetReq from the next cycle for exactly 4 cycles. It also sets the fault flag, which reads as bit 4 of the status register (address 0xF4).
- R10: The fault flag stays set until bit 7 is written as 1 to the acknowledge register (address 0xD8). A write with bit 7 at 0 leaves the flag set.
- R11: The key register always reads 0x00, even right after a key write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz reference clock |
| rstN | input | 1 | Power-on reset, active low |
| sfrWrEn | input | 1 | Register write strobe |
| sfrAddr | input | 8 | Register address for writes and reads |
| sfrWrData | input | 8 | Write data |
| sfrRdData | output | 8 | Read data for sfrAddr |
| pllLocked | input | 1 | Synthesizer lock indication |
| coreClkEn | output | 1 | Core clock enable pulse |
| meterClkEn | output | 1 | Metering clock enable pulse |
| coreOff | output | 1 | Core shutdown request |
| meterOff | output | 1 | Metering shutdown request |
| resetReq | output | 1 | Core reset request |
| activeCd | output | 3 | Divider exponent currently in use |

## Verification
All eight exponent values are swept, and the pulse spacing of both enables is measured arithmetically at each one. This shows whether the core divider follows 2^n while the metering divider stays at 5. A switch from the slowest to the fastest setting is made partway through a period, which shows whether the switch waits for the period boundary. Write sequences cover the right key, no key, the time-keeping key, a foreign key and a write to some other register between key and target, which tells apart single-use unlocking and key value checking. A loss of lock, followed by a zero acknowledge and then a real one, separates the reset pulse length from the stickiness of the flag.

// File: rtl/clkpwr_pkg.sv
`timescale 1ns/1ps
package clkpwr_pkg;
  localparam int CD_W = 3;

  typedef struct packed {
    logic            pwrWr;
    logic            ackWr;
    logic            rdPwr;
    logic            rdStat;
    logic [CD_W-1:0] newCd;
    logic            newMeterOff;
    logic            newCoreOff;
  } ctlStrb_t;
endpackage

// File: rtl/clkpwr_ctl.sv
`timescale 1ns/1ps
module clkpwr_ctl
  import clkpwr_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  KEY_ADDR  = 8'hC1,
  parameter logic [7:0]  PWR_ADDR  = 8'hC5,
  parameter logic [7:0]  STAT_ADDR = 8'hF4,
  parameter logic [7:0]  ACK_ADDR  = 8'hD8,
  parameter logic [7:0]  PWR_KEY   = 8'hA7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sfrWrEn,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic [7:0]        sfrWrData,
  output ctlStrb_t          strb
);
  logic armed;
  logic rsvdUnused;

  assign rsvdUnused = ^{sfrWrData[5], sfrWrData[3]};

  // Unlock lives for exactly one following write of any kind
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        armed <= 1'b0;
    else if (sfrWrEn) armed <= (sfrAddr == ADDR_W'(KEY_ADDR)) && (sfrWrData == PWR_KEY);
  end

  always_comb begin
    strb             = '0;
    strb.pwrWr       = sfrWrEn && (sfrAddr == ADDR_W'(PWR_ADDR)) && armed;
    strb.ackWr       = sfrWrEn && (sfrAddr == ADDR_W'(ACK_ADDR)) && sfrWrData[7];
    strb.rdPwr       = (sfrAddr == ADDR_W'(PWR_ADDR));
    strb.rdStat      = (sfrAddr == ADDR_W'(STAT_ADDR));
    strb.newCd       = sfrWrData[CD_W-1:0];
    strb.newMeterOff = sfrWrData[6];
    strb.newCoreOff  = sfrWrData[4];
  end

  // R3: a consumed unlock never survives the write that used it
  a_r3_unlock_single_use: assert property (@(posedge clk) disable iff (!rstN)
    strb.pwrWr |=> !armed);

  // R4: any key byte other than the power key leaves the register locked
  a_r4_wrong_key_locks: assert property (@(posedge clk) disable iff (!rstN)
    (sfrWrEn && sfrAddr == ADDR_W'(KEY_ADDR) && sfrWrData != PWR_KEY) |=> !armed);
endmodule

// File: rtl/clkpwr_dp.sv
`timescale 1ns/1ps
module clkpwr_dp
  import clkpwr_pkg::*;
#(
  parameter logic [CD_W-1:0] CD_RESET  = 3'd2,
  parameter int              METER_DIV = 5,
  parameter int              RST_HOLD  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrb_t        strb,
  input  logic            pllLocked,
  output logic [7:0]      rdData,
  output logic            coreClkEn,
  output logic            meterClkEn,
  output logic            coreOff,
  output logic            meterOff,
  output logic            resetReq,
  output logic [CD_W-1:0] activeCd
);
  localparam int CORE_CNT_W  = (1 << CD_W) - 1;
  localparam int METER_CNT_W = $clog2(METER_DIV);
  localparam int RST_CNT_W   = $clog2(RST_HOLD + 1);

  logic [CD_W-1:0]        pendCd;
  logic                   meterOffQ, coreOffQ;
  logic [CORE_CNT_W-1:0]  coreCnt;
  logic [CORE_CNT_W:0]    periodFull;
  logic [CORE_CNT_W-1:0]  coreReload;
  logic [METER_CNT_W-1:0] meterCnt;
  logic [RST_CNT_W-1:0]   rstCnt;
  logic                   lockPrev, pllFault, lossDet;

  // Power-control fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCd    <= CD_RESET;
      meterOffQ <= 1'b0;
      coreOffQ  <= 1'b0;
    end else if (strb.pwrWr) begin
      pendCd    <= strb.newCd;
      meterOffQ <= strb.newMeterOff;
      coreOffQ  <= strb.newCoreOff;
    end
  end

  // Core divider: down counter, new exponent loaded only at a period end
  assign periodFull = (CORE_CNT_W+1)'(1) << pendCd;
  assign coreReload = CORE_CNT_W'(periodFull - 1'b1);
  assign coreClkEn  = (coreCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreCnt  <= '0;
      activeCd <= CD_RESET;
    end else if (coreClkEn) begin
      coreCnt  <= coreReload;
      activeCd <= pendCd;
    end else begin
      coreCnt  <= coreCnt - 1'b1;
    end
  end

  // Metering divider: fixed modulus, independent of the exponent
  assign meterClkEn = (meterCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                         meterCnt <= '0;
    else if (meterCnt == METER_CNT_W'(METER_DIV - 1))  meterCnt <= '0;
    else                                               meterCnt <= meterCnt + 1'b1;
  end

  // Lock loss: reset pulse and sticky fault
  assign lossDet  = lockPrev && !pllLocked;
  assign resetReq = (rstCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockPrev <= 1'b0;
      rstCnt   <= '0;
      pllFault <= 1'b0;
    end else begin
      lockPrev <= pllLocked;
      if (lossDet)       rstCnt <= RST_CNT_W'(RST_HOLD);
      else if (resetReq) rstCnt <= rstCnt - 1'b1;
      if (lossDet)          pllFault <= 1'b1;
      else if (strb.ackWr)  pllFault <= 1'b0;
    end
  end

  // Readback with fixed reserved levels
  always_comb begin
    rdData = 8'h00;
    if (strb.rdPwr)       rdData = {1'b1, meterOffQ, 1'b0, coreOffQ, 1'b0, pendCd};
    else if (strb.rdStat) rdData = {3'b000, pllFault, 4'b0000};
  end

  assign coreOff  = coreOffQ;
  assign meterOff = meterOffQ;

  // R2: stored exponent moves only on an unlocked power-register write
  a_r2_cd_needs_unlock: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pendCd) |-> $past(strb.pwrWr));

  // R6: the exponent in use changes only right after a period end
  a_r6_switch_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeCd) |-> $past(coreClkEn));

  // R5: for any exponent above zero, enable pulses are single cycles
  a_r5_core_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    (coreClkEn && pendCd != '0) |=> !coreClkEn);

  // R7: metering enable never lasts two cycles
  a_r7_meter_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    meterClkEn |=> !meterClkEn);

  // R9: lock loss raises reset and fault in the next cycle
  a_r9_loss_resets: assert property (@(posedge clk) disable iff (!rstN)
    (lockPrev && !pllLocked) |=> (resetReq && pllFault));

  // R10: the fault only clears after an acknowledge
  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pllFault) |-> $past(strb.ackWr));
endmodule

// File: rtl/clkpwr_unit.sv
`timescale 1ns/1ps
module clkpwr_unit
  import clkpwr_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] KEY_ADDR  = 8'hC1,
  parameter logic [7:0] PWR_ADDR  = 8'hC5,
  parameter logic [7:0] STAT_ADDR = 8'hF4,
  parameter logic [7:0] ACK_ADDR  = 8'hD8,
  parameter logic [7:0] PWR_KEY   = 8'hA7,
  parameter int         METER_DIV = 5,
  parameter int         RST_HOLD  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sfrWrEn,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic [7:0]        sfrWrData,
  output logic [7:0]        sfrRdData,
  input  logic              pllLocked,
  output logic              coreClkEn,
  output logic              meterClkEn,
  output logic              coreOff,
  output logic              meterOff,
  output logic              resetReq,
  output logic [2:0]        activeCd
);
  ctlStrb_t strb;

  clkpwr_ctl #(
    .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .PWR_ADDR(PWR_ADDR),
    .STAT_ADDR(STAT_ADDR), .ACK_ADDR(ACK_ADDR), .PWR_KEY(PWR_KEY)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .sfrWrEn(sfrWrEn), .sfrAddr(sfrAddr),
    .sfrWrData(sfrWrData), .strb(strb)
  );

  clkpwr_dp #(
    .CD_RESET(3'd2), .METER_DIV(METER_DIV), .RST_HOLD(RST_HOLD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pllLocked(pllLocked),
    .rdData(sfrRdData), .coreClkEn(coreClkEn), .meterClkEn(meterClkEn),
    .coreOff(coreOff), .meterOff(meterOff), .resetReq(resetReq),
    .activeCd(activeCd)
  );
endmodule

// File: tb/clkpwr_unit_test.sv
`timescale 1ns/1ps
module clkpwr_unit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sfrWrEn = 1'b0;
  logic [7:0] sfrAddr = 8'h00;
  logic [7:0] sfrWrData = 8'h00;
  logic [7:0] sfrRdData;
  logic       pllLocked = 1'b1;
  logic       coreClkEn, meterClkEn, coreOff, meterOff, resetReq;
  logic [2:0] activeCd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] KEY = 8'hC1, PWR = 8'hC5, STAT = 8'hF4, ACK = 8'hD8;

  always #2 clk = ~clk;

  clkpwr_unit uut (
    .clk(clk), .rstN(rstN), .sfrWrEn(sfrWrEn), .sfrAddr(sfrAddr),
    .sfrWrData(sfrWrData), .sfrRdData(sfrRdData), .pllLocked(pllLocked),
    .coreClkEn(coreClkEn), .meterClkEn(meterClkEn), .coreOff(coreOff),
    .meterOff(meterOff), .resetReq(resetReq), .activeCd(activeCd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfrWrEn = 1'b1; sfrAddr = a; sfrWrData = d;
    @(negedge clk);
    sfrWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    sfrAddr = a;
    #0.5 d = sfrRdData;
  endtask

  task automatic waitCore();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (coreClkEn) return;
    end
  endtask

  task automatic coreGap(output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      n++;
      if (coreClkEn) return;
    end
  endtask

  task automatic meterGap(output int n);
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (meterClkEn) break;
    end
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      n++;
      if (meterClkEn) return;
    end
  endtask

  function automatic logic [7:0] pwrView(input logic [7:0] d);
    return (d & 8'h57) | 8'h80;
  endfunction

  initial begin
    logic [7:0] v;
    int gap, gap2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 activeCd", activeCd, 2);
    chk("R1 resetReq", resetReq, 0);
    chk("R1 coreOff/meterOff", {coreOff, meterOff}, 0);
    rd(PWR, v);  chk("R1 power reg", v, 8'h82);
    rd(STAT, v); chk("R1 status reg", v, 8'h00);
    waitCore(); coreGap(gap); chk("R1 core period", gap, 4);

    // R11 key reads zero; R2 unlocked write; R8 reserved levels and outputs
    wr(KEY, 8'hA7);
    rd(KEY, v); chk("R11 key readback", v, 0);
    wr(PWR, 8'hFF);
    rd(PWR, v); chk("R8 reserved bits / R2 write", v, pwrView(8'hFF));
    chk("R8 coreOff", coreOff, 1);
    chk("R8 meterOff", meterOff, 1);
    wr(PWR, 8'h02);
    rd(PWR, v); chk("R2 write without key ignored", v, pwrView(8'hFF));
    wr(KEY, 8'hA7); wr(8'h90, 8'h00); wr(PWR, 8'h05);
    rd(PWR, v); chk("R3 other write consumes unlock", v, pwrView(8'hFF));
    wr(KEY, 8'hA7); wr(KEY, 8'h11); wr(PWR, 8'h05);
    rd(PWR, v); chk("R3 second key byte consumes unlock", v, pwrView(8'hFF));
    wr(KEY, 8'hEA); wr(PWR, 8'h05);
    rd(PWR, v); chk("R4 timekeeping key does not unlock", v, pwrView(8'hFF));
    wr(KEY, 8'hA7); wr(PWR, 8'h42);
    rd(PWR, v); chk("R2 keyed write", v, 8'hC2);
    chk("R8 coreOff cleared", coreOff, 0);
    chk("R8 meterOff kept", meterOff, 1);

    // R5 and R7 sweep of every exponent
    for (int cd = 0; cd < 8; cd++) begin
      wr(KEY, 8'hA7); wr(PWR, 8'(cd));
      waitCore();
      coreGap(gap); coreGap(gap2);
      chk($sformatf("R5 core period cd=%0d", cd), gap, 1 << cd);
      chk($sformatf("R5 core period repeat cd=%0d", cd), gap2, 1 << cd);
      chk($sformatf("R5 activeCd cd=%0d", cd), activeCd, cd);
      meterGap(gap);
      chk($sformatf("R7 meter period cd=%0d", cd), gap, 5);
    end

    // R6 switch from slowest to fastest in mid period
    waitCore();
    fork
      coreGap(gap);
      begin
        repeat (10) @(negedge clk);
        wr(KEY, 8'hA7); wr(PWR, 8'h00);
      end
    join
    chk("R6 running period kept", gap, 128);
    coreGap(gap);
    chk("R6 new period after boundary", gap, 1);

    // R9 lock loss
    @(negedge clk);
    pllLocked = 1'b0;
    chk("R9 no reset before edge", resetReq, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk($sformatf("R9 resetReq cycle %0d", i), resetReq, 1);
    end
    @(negedge clk);
    chk("R9 resetReq ends after 4", resetReq, 0);
    pllLocked = 1'b1;
    rd(STAT, v); chk("R9 fault flag set", v, 8'h10);

    // R10 acknowledge
    wr(ACK, 8'h7F);
    rd(STAT, v); chk("R10 zero ack keeps flag", v, 8'h10);
    wr(ACK, 8'h80);
    rd(STAT, v); chk("R10 ack clears flag", v, 8'h00);
    meterGap(gap); chk("R7 meter period at end", gap, 5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule